// File: doc/BRIEF.md
# Serial Port Interrupt Controller

This block raises and masks the interrupts of a synchronous serial port that has an 8-entry transmit queue and an 8-entry receive queue. The queues, the shifter and the bit-clock divider live elsewhere. The block only sees these signals from them:

- both occupancy counts,
- the receive queue's push and pop strobes,
- a one-cycle tick per serial bit period.

From these it forms four raw conditions:

- **transmit low-water:** the transmit queue has room.
- **receive high-water:** the receive queue is filling.
- **receive timeout:** data has been left unread for a fixed number of bit periods.
- **receive overrun:** a push arrived while the receive queue was full. The queue itself drops that word.

Software sees the block through a 16-bit register port with four addresses:

| Address | Register | Access |
|---|---|---|
| 0 | Enable mask | read/write |
| 1 | Raw status | read-only |
| 2 | Masked status | read-only |
| 3 | Clear | write-only |

Each enabled condition drives its own registered interrupt line. A fifth registered line is the OR of the four.

No data stream passes through this block, so it has no valid/ready handshake. All inputs are plain level or strobe signals, and the block cannot stall or refuse any of them. Register writes take effect on the clock edge where `reg_wr` is high. Reads are combinational from `reg_addr`.

Top module: `sio_irq_unit`

## Requirements
- R1: The enable mask at address 0 resets to zero, takes `reg_wdata[3:0]` on a write (a 1 enables and a 0 disables), and reads back the current mask. Bits 15 to 4 of every read are zero.
- R2: Raw status at address 1 has this layout: bit 3 transmit low-water, bit 2 receive high-water, bit 1 timeout, bit 0 overrun. A write to address 1 changes nothing.
- R3: Raw bit 3 is 1 exactly when `tx_level` is 4 or less.
- R4: Raw bit 2 is 1 exactly when `rx_level` is 4 or more.
- R5: The timeout flag (raw bit 1) sets on the 32nd `bit_tick` counted while `rx_level` is nonzero with no push or pop. Any push or pop restarts the count from zero, and an empty receive queue holds the count at zero.
- R6: The timeout flag clears on a pop, on `rx_level` equal to 0, or on a write of 1 to bit 1 at address 3.
- R7: The overrun flag (raw bit 0) sets on a push while `rx_level` equals 8. It stays set until a write of 1 to bit 0 at address 3.
- R8: Masked status at address 2 reads raw AND mask. Address 3 reads as zero.
- R9: Each `irq_*_o` line equals its masked status bit one clock later. `irq_any_o` is the OR of the four masked bits, one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_level | input | 4 | Transmit queue occupancy, 0 to 8 |
| rx_level | input | 4 | Receive queue occupancy, 0 to 8 |
| rx_push | input | 1 | Receive queue write strobe |
| rx_pop | input | 1 | Receive queue read strobe |
| bit_tick | input | 1 | One pulse per serial bit period |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| irq_tx_o | output | 1 | Transmit low-water interrupt |
| irq_rx_o | output | 1 | Receive high-water interrupt |
| irq_tmo_o | output | 1 | Receive timeout interrupt |
| irq_ovr_o | output | 1 | Receive overrun interrupt |
| irq_any_o | output | 1 | OR of all enabled interrupts |

## Verification
The bench sweeps every combination of transmit level, receive level and mask value.

- **Threshold placement:** a design with a threshold one entry off would miscompare at occupancy 4.
- **Timeout count:** the timeout is checked after 31 and after 32 ticks. An off-by-one counter would flag a tick early or late.
- **Timeout restart:** a push at tick 20 must restart the count. A counter that failed to restart would fire 20 ticks too soon.
- **Overrun persistence:** the overrun flag must survive a pop, a drain of the queue, a write to the raw register and a timeout-only clear. A flag that was level-based or cleared on the wrong bit would drop early.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int NUM_IRQ = 4;
  localparam int REG_W   = 16;
  localparam int BIT_TX  = 3;
  localparam int BIT_RX  = 2;
  localparam int BIT_TMO = 1;
  localparam int BIT_OVR = 0;

  typedef enum logic [1:0] {
    ADDR_MASK = 2'd0,
    ADDR_RAW  = 2'd1,
    ADDR_MIS  = 2'd2,
    ADDR_CLR  = 2'd3
  } irq_addr_e;
endpackage

// File: rtl/sio_irq_tmo.sv
module sio_irq_tmo #(
  parameter int TMO_TICKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_empty,
  input  logic rx_push,
  input  logic rx_pop,
  input  logic bit_tick,
  input  logic sw_clr,
  output logic flag_q
);
  localparam int CNT_W = (TMO_TICKS > 1) ? $clog2(TMO_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             restart;
  logic             expire;

  assign restart = rx_empty | rx_push | rx_pop;
  assign expire  = !restart && bit_tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (bit_tick) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (expire) begin
      flag_q <= 1'b1;
    end else if (rx_pop || rx_empty || sw_clr) begin
      flag_q <= 1'b0;
    end
  end

  // R5
  tmo_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(bit_tick) && !$past(rx_empty));

  // R6
  tmo_pop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |=> !flag_q);
endmodule

// File: rtl/sio_irq_ovr.sv
module sio_irq_ovr (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_full,
  input  logic rx_push,
  input  logic sw_clr,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (rx_push && rx_full) begin
      flag_q <= 1'b1;
    end else if (sw_clr) begin
      flag_q <= 1'b0;
    end
  end

  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !sw_clr |=> flag_q);
endmodule

// File: rtl/sio_irq_regs.sv
module sio_irq_regs
  import sio_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         reg_addr,
  input  logic               reg_wr,
  input  logic [REG_W-1:0]   reg_wdata,
  input  logic [NUM_IRQ-1:0] raw,
  output logic [NUM_IRQ-1:0] mask_q,
  output logic               clr_tmo,
  output logic               clr_ovr,
  output logic [REG_W-1:0]   reg_rdata
);
  irq_addr_e addr;
  logic      unused_hi;

  assign addr      = irq_addr_e'(reg_addr);
  assign unused_hi = ^reg_wdata[REG_W-1:NUM_IRQ];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (reg_wr && addr == ADDR_MASK) begin
      mask_q <= reg_wdata[NUM_IRQ-1:0];
    end
  end

  assign clr_tmo = reg_wr && (addr == ADDR_CLR) && reg_wdata[BIT_TMO];
  assign clr_ovr = reg_wr && (addr == ADDR_CLR) && reg_wdata[BIT_OVR];

  always_comb begin
    reg_rdata = '0;
    case (addr)
      ADDR_MASK: reg_rdata[NUM_IRQ-1:0] = mask_q;
      ADDR_RAW:  reg_rdata[NUM_IRQ-1:0] = raw;
      ADDR_MIS:  reg_rdata[NUM_IRQ-1:0] = raw & mask_q;
      default:   reg_rdata = '0;
    endcase
  end

  // R1
  rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[REG_W-1:NUM_IRQ] == '0);
endmodule

// File: rtl/sio_irq_unit.sv
module sio_irq_unit
  import sio_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int TMO_TICKS  = 32,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             bit_tick,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq_tx_o,
  output logic             irq_rx_o,
  output logic             irq_tmo_o,
  output logic             irq_ovr_o,
  output logic             irq_any_o
);
  localparam logic [LVL_W-1:0] HALF = LVL_W'(FIFO_DEPTH / 2);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(FIFO_DEPTH);

  logic [NUM_IRQ-1:0] raw;
  logic [NUM_IRQ-1:0] mask;
  logic [NUM_IRQ-1:0] irq_q;
  logic               irq_any_q;
  logic               tmo_flag, ovr_flag, clr_tmo, clr_ovr;
  logic               rx_empty, rx_full;

  assign rx_empty = (rx_level == '0);
  assign rx_full  = (rx_level >= FULL);

  assign raw[BIT_TX]  = (tx_level <= HALF);
  assign raw[BIT_RX]  = (rx_level >= HALF);
  assign raw[BIT_TMO] = tmo_flag;
  assign raw[BIT_OVR] = ovr_flag;

  sio_irq_tmo #(.TMO_TICKS(TMO_TICKS)) u_tmo (
    .clk(clk), .rst_n(rst_n), .rx_empty(rx_empty), .rx_push(rx_push),
    .rx_pop(rx_pop), .bit_tick(bit_tick), .sw_clr(clr_tmo), .flag_q(tmo_flag)
  );

  sio_irq_ovr u_ovr (
    .clk(clk), .rst_n(rst_n), .rx_full(rx_full), .rx_push(rx_push),
    .sw_clr(clr_ovr), .flag_q(ovr_flag)
  );

  sio_irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .raw(raw), .mask_q(mask), .clr_tmo(clr_tmo),
    .clr_ovr(clr_ovr), .reg_rdata(reg_rdata)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) irq_q[i] <= 1'b0;
      else        irq_q[i] <= raw[i] & mask[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_any_q <= 1'b0;
    else        irq_any_q <= |(raw & mask);
  end

  assign irq_tx_o  = irq_q[BIT_TX];
  assign irq_rx_o  = irq_q[BIT_RX];
  assign irq_tmo_o = irq_q[BIT_TMO];
  assign irq_ovr_o = irq_q[BIT_OVR];
  assign irq_any_o = irq_any_q;

  // R9
  irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_q == $past(raw & mask));

  // R9
  irq_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any_o == (irq_q != '0));
endmodule

// File: tb/test_sio_irq_unit.sv
`timescale 1ns/1ps
module test_sio_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  tx_level = '0, rx_level = '0;
  logic        rx_push = 0, rx_pop = 0, bit_tick = 0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_tx_o, irq_rx_o, irq_tmo_o, irq_ovr_o, irq_any_o;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sio_irq_unit i_sio_irq_unit (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
    .rx_push(rx_push), .rx_pop(rx_pop), .bit_tick(bit_tick),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_tx_o(irq_tx_o), .irq_rx_o(irq_rx_o),
    .irq_tmo_o(irq_tmo_o), .irq_ovr_o(irq_ovr_o), .irq_any_o(irq_any_o)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #0.1;
    d = reg_rdata;
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic ticks(int n);
    bit_tick = 1'b1;
    repeat (n) step();
    bit_tick = 1'b0;
  endtask

  task automatic pulse_pop();
    rx_pop = 1'b1; step(); rx_pop = 1'b0;
  endtask

  task automatic pulse_push();
    rx_push = 1'b1; step(); rx_push = 1'b0;
  endtask

  function automatic logic [15:0] bit_of(logic [15:0] v, int b);
    return {15'd0, v[b]};
  endfunction

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    @(negedge clk);
    repeat (3) step();

    // Reset state, checked while reset is still held
    rd(2'd0, d); chk("R1 reset mask", d, 16'h0000);
    chk("R9 reset lines",
        {11'd0, irq_tx_o, irq_rx_o, irq_tmo_o, irq_ovr_o, irq_any_o}, 16'h0);
    rst_n = 1'b1;
    step();

    // R1: mask write and read back; upper bits are never stored
    wr(2'd0, 16'hFFFF); rd(2'd0, d); chk("R1 mask upper zero", d, 16'h000F);
    wr(2'd0, 16'h0005); rd(2'd0, d); chk("R1 mask readback", d, 16'h0005);

    // R8: the clear register reads as zero
    rd(2'd3, d); chk("R8 clear reads zero", d, 16'h0000);

    // R3 R4 R8 R9: every mask, transmit level and receive level
    for (int m = 0; m < 16; m++) begin
      wr(2'd0, 16'(m));
      for (int t = 0; t <= 8; t++) begin
        for (int r = 0; r <= 8; r++) begin
          logic [15:0] raw_e, mis_e;
          tx_level = 4'(t);
          rx_level = 4'(r);
          step();
          raw_e = {12'd0, (t <= 4), (r >= 4), 2'b00};
          mis_e = raw_e & 16'(m);
          rd(2'd1, d); chk("R3 R4 raw levels", d, raw_e);
          rd(2'd2, d); chk("R8 masked status", d, mis_e);
          chk("R9 lines",
              {11'd0, irq_tx_o, irq_rx_o, irq_tmo_o, irq_ovr_o, irq_any_o},
              {11'd0, mis_e[3:0], |mis_e});
        end
      end
    end

    // R5: timeout after exactly 32 ticks
    wr(2'd0, 16'h000F);
    tx_level = 4'd8; rx_level = 4'd2;
    pulse_pop();
    ticks(31); rd(2'd1, d); chk("R5 no timeout at 31", bit_of(d, 1), 16'd0);
    ticks(1);  rd(2'd1, d); chk("R5 timeout at 32", bit_of(d, 1), 16'd1);
    step(); chk("R9 timeout line", {15'd0, irq_tmo_o}, 16'd1);

    // R6: a pop clears the flag
    pulse_pop(); rd(2'd1, d); chk("R6 pop clears", bit_of(d, 1), 16'd0);

    // R5: a push restarts the count
    ticks(20); pulse_push(); ticks(20);
    rd(2'd1, d); chk("R5 push restarts", bit_of(d, 1), 16'd0);
    ticks(12); rd(2'd1, d); chk("R5 timeout after restart", bit_of(d, 1), 16'd1);

    // R6: software clear through bit 1
    wr(2'd3, 16'h0002); rd(2'd1, d); chk("R6 sw clear", bit_of(d, 1), 16'd0);
    ticks(32); rd(2'd1, d); chk("R5 timeout again", bit_of(d, 1), 16'd1);

    // R6: emptying clears; an empty queue never times out
    rx_level = 4'd0; step();
    rd(2'd1, d); chk("R6 empty clears", bit_of(d, 1), 16'd0);
    ticks(40); rd(2'd1, d); chk("R5 empty no timeout", bit_of(d, 1), 16'd0);

    // R7: overrun only on a push while full, sticky afterwards
    rx_level = 4'd7; pulse_push();
    rd(2'd1, d); chk("R7 no overrun at 7", bit_of(d, 0), 16'd0);
    rx_level = 4'd8; pulse_push();
    rd(2'd1, d); chk("R7 overrun at 8", bit_of(d, 0), 16'd1);
    step(); chk("R9 overrun line", {15'd0, irq_ovr_o}, 16'd1);
    rx_level = 4'd2; pulse_pop();
    rd(2'd1, d); chk("R7 sticky after pop", bit_of(d, 0), 16'd1);
    rx_level = 4'd0; step();
    rd(2'd1, d); chk("R7 sticky when empty", bit_of(d, 0), 16'd1);
    wr(2'd1, 16'h0000);
    rd(2'd1, d); chk("R2 raw write ignored", bit_of(d, 0), 16'd1);
    wr(2'd3, 16'h0002);
    rd(2'd1, d); chk("R7 tmo clear leaves overrun", bit_of(d, 0), 16'd1);
    wr(2'd3, 16'h0001);
    rd(2'd1, d); chk("R7 sw clear", bit_of(d, 0), 16'd0);
    rd(2'd0, d); chk("R2 mask unchanged", d, 16'h000F);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule